// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is the segment table of a 64-bit hashed-paging memory unit. It holds a small set of fully associative segment entries. Each entry keeps an effective segment tag with a valid flag, a 64-bit virtual segment word, a segment-size flag and the index of a decoded page size. A translation front end drives an effective address into a combinational lookup port. That port returns the matching slot and its page shift in the same cycle.

A single command port carries the maintenance operations. These are a checked store to a numbered slot and reads of either word of a slot. There is also a find-by-address read that returns the virtual segment word, or all ones on a miss. Two invalidate forms exist: invalidate-all, which always spares slot 0, and invalidate-by-address, which comes in a local and a global variant. Command results, error pulses and flush requests are registered and appear one cycle after the command. The page-table walk, the TLB and exception delivery sit outside this block. They consume the error and flush pulses.

Top module: `seg_lookaside`

## Requirements
- R1: An entry matches an address only if its valid flag (tag bit 27) is set. The virtual word of the entry carries its size code in bits 63:62, where 00 means 256 MB and 01 means 1 TB. A 256 MB entry matches when its tag bits 63:28 equal address bits 63:28. A 1 TB entry matches when its tag bits 63:40 equal address bits 63:40 and its tag bits 39:28 are zero.
- R2: The lookup port is combinational and reflects the table as it stood at the start of the cycle. When several entries match, the lowest-numbered slot is reported.
- R3: A store takes its slot number from operand bits 11:0 and its tag word from operand bits 63:12, with the low 12 bits of the tag word held at zero. It stores the virtual word verbatim. The new entry is visible to lookups from the next cycle on.
- R4: A store is rejected when any of these holds: the slot is not below ENTRIES, operand bits 26:12 are nonzero, the size code is 10 or 11, the size code is 01 while one_tb_en is low, or the page code matches no configured encoding. A rejected store pulses err one cycle later and changes nothing.
- R5: The page code is virtual-word bits 6:4. It is decoded through a parameter table in which the first match wins. The default table maps 0 to shift 12, 4 to shift 16 and 5 to shift 24. On a hit, lk_shift gives the shift of the matching entry; on a miss, lk_shift is 0.
- R6: The read-tag and read-virtual-word commands return the stored word of the slot with rd_valid one cycle later. A slot number not below ENTRIES gives err instead, with no rd_valid.
- R7: Find-by-address returns the virtual word of the matching slot with rd_valid. When mode64 is low it first clears address bits 63:32. On a miss it returns all ones.
- R8: Invalidate-all clears the valid flag of every slot except slot 0. It pulses flush_local if any of the slots it covers was valid.
- R9: Invalidate-by-address clears the valid flag of the matching slot. It then pulses flush_local for the local variant and flush_global for the global variant. A miss changes nothing and raises no flush.
- R10: A synchronous active-high reset leaves every entry invalid, with lk_hit, rd_valid, rd_data, err and both flush outputs at zero.
- R11: cmd_op encodes the commands as follows: 0 idle, 1 store, 2 read tag, 3 read virtual word, 4 find, 5 invalidate-all, 6 invalidate local, 7 invalidate global. The idle command raises no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 64-bit addressing mode; when low, find uses only address bits 31:0 |
| one_tb_en | input | 1 | Permits stores of 1 TB segments |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 64 | Command operand: slot and tag word, or effective address |
| cmd_vsid | input | 64 | Virtual segment word for a store |
| lk_addr | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_slot | output | $clog2(ENTRIES) | Matching slot, lowest number first |
| lk_shift | output | 6 | Page shift of the matching entry |
| rd_valid | output | 1 | Read or find result is valid |
| rd_data | output | 64 | Read or find result |
| err | output | 1 | Store or read rejected |
| flush_local | output | 1 | Local translation flush request |
| flush_global | output | 1 | Global translation flush request |

## Verification
The lookup port and a table-changing command can fall in the same cycle. The bench provokes this by pointing lk_addr at the tag that a store writes, or that an invalidate clears, in the very cycle that command is applied. The lookup is judged against the reference table as it stood before the command, and then against the updated table in the following cycle. The same overlap is also provoked in the random phase, where the lookup address and the command operand are drawn from a shared pool of segment bases.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int ADDR_W    = 64;
  localparam int TAG_LO    = 27;             // valid flag position
  localparam int TAG_W     = ADDR_W - TAG_LO; // bits 63:27
  localparam int SLOTF_W   = 12;
  localparam int PCODE_W   = 3;
  localparam int PCODE_LO  = 4;
  localparam int SHIFT_W   = 6;
  localparam int MAX_PS    = 4;
  localparam int PIDX_W    = $clog2(MAX_PS);
  localparam int SEG256_LO = 28;
  localparam int SEG1T_LO  = 40;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_STORE  = 3'd1,
    OP_RTAG   = 3'd2,
    OP_RVSID  = 3'd3,
    OP_FIND   = 3'd4,
    OP_INVALL = 3'd5,
    OP_INVL   = 3'd6,
    OP_INVG   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RK_TAG  = 2'd0,
    RK_VSID = 2'd1,
    RK_ONES = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/slb_seg_match.sv
module slb_seg_match
  import slb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int SW      = $clog2(ENTRIES)
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [ENTRIES-1:0]            big,
  output logic                          hit,
  output logic [SW-1:0]                 slot
);
  localparam int ZW = SEG1T_LO - SEG256_LO;

  logic [TAG_W-1:0]   key_small;
  logic [TAG_W-1:0]   key_big;
  logic [ENTRIES-1:0] match;

  // Both size keys carry the valid flag so an invalid entry never matches.
  assign key_small = {addr[ADDR_W-1:SEG256_LO], 1'b1};
  assign key_big   = {addr[ADDR_W-1:SEG1T_LO], {ZW{1'b0}}, 1'b1};

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = big[g] ? (tags[g] == key_big) : (tags[g] == key_small);
    end
  endgenerate

  // Priority pick: scanning downward leaves the lowest match in place.
  always_comb begin
    hit  = |match;
    slot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) slot = SW'(i);
    end
  end
endmodule

// File: rtl/slb_store_check.sv
module slb_store_check
  import slb_pkg::*;
#(
  parameter int                        ENTRIES  = 32,
  parameter int                        PS_COUNT = 3,
  parameter logic [MAX_PS*PCODE_W-1:0] PS_ENC   = {3'd0, 3'd5, 3'd4, 3'd0}
) (
  input  logic [ADDR_W-1:0] opnd,
  input  logic [ADDR_W-1:0] vsid,
  input  logic              one_tb_en,
  output logic              ok,
  output logic [PIDX_W-1:0] pidx
);
  logic [SLOTF_W-1:0] slot_f;
  logic               range_ok;
  logic               rsvd_ok;
  logic               size_ok;
  logic               page_ok;
  logic [1:0]         size_code;
  logic [PCODE_W-1:0] pcode;

  assign slot_f    = opnd[SLOTF_W-1:0];
  assign size_code = vsid[ADDR_W-1 -: 2];
  assign pcode     = vsid[PCODE_LO +: PCODE_W];
  assign range_ok  = 32'(slot_f) < ENTRIES;
  assign rsvd_ok   = (opnd[TAG_LO-1:SLOTF_W] == '0);
  assign size_ok   = (size_code == 2'b00) || (size_code == 2'b01 && one_tb_en);

  always_comb begin
    page_ok = 1'b0;
    pidx    = '0;
    for (int i = 0; i < PS_COUNT; i++) begin
      if (!page_ok && pcode == PS_ENC[i*PCODE_W +: PCODE_W]) begin
        page_ok = 1'b1;
        pidx    = PIDX_W'(i);
      end
    end
  end

  assign ok = range_ok && rsvd_ok && size_ok && page_ok;
endmodule

// File: rtl/seg_lookaside.sv
module seg_lookaside
  import slb_pkg::*;
#(
  parameter int                        ENTRIES  = 32,
  parameter int                        PS_COUNT = 3,
  parameter logic [MAX_PS*PCODE_W-1:0] PS_ENC   = {3'd0, 3'd5, 3'd4, 3'd0},
  parameter logic [MAX_PS*SHIFT_W-1:0] PS_SHIFT = {6'd0, 6'd24, 6'd16, 6'd12}
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        mode64,
  input  logic                        one_tb_en,
  input  logic [2:0]                  cmd_op,
  input  logic [63:0]                 cmd_addr,
  input  logic [63:0]                 cmd_vsid,
  input  logic [63:0]                 lk_addr,
  output logic                        lk_hit,
  output logic [$clog2(ENTRIES)-1:0]  lk_slot,
  output logic [5:0]                  lk_shift,
  output logic                        rd_valid,
  output logic [63:0]                 rd_data,
  output logic                        err,
  output logic                        flush_local,
  output logic                        flush_global
);
  localparam int SW = $clog2(ENTRIES);

  // Tags, size flags and page indices are flops: every entry is compared at once.
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0]             big_q;
  logic [ENTRIES-1:0][PIDX_W-1:0] pidx_q;
  // Virtual words are only ever read one slot at a time: memory with a registered read.
  logic [ADDR_W-1:0]              vsid_mem [ENTRIES];
  logic [ADDR_W-1:0]              vsid_q;
  logic [ADDR_W-1:0]              tag_rd_q;
  rd_kind_e                       kind_q;

  op_e                 op;
  logic [SLOTF_W-1:0]  slot_f;
  logic [SW-1:0]       slot_i;
  logic                slot_in_range;
  logic [ADDR_W-1:0]   c_addr;
  logic                c_hit;
  logic [SW-1:0]       c_slot;
  logic                chk_ok;
  logic [PIDX_W-1:0]   chk_pidx;
  logic                wr_en;
  logic [SW-1:0]       rd_idx;
  logic [ENTRIES-1:0]  valid_v;

  assign op            = op_e'(cmd_op);
  assign slot_f        = cmd_addr[SLOTF_W-1:0];
  assign slot_i        = slot_f[SW-1:0];
  assign slot_in_range = 32'(slot_f) < ENTRIES;
  assign c_addr        = (op == OP_FIND && !mode64) ? {32'b0, cmd_addr[31:0]} : cmd_addr;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_valid
      assign valid_v[g] = tag_q[g][0];
    end
  endgenerate

  slb_seg_match #(.ENTRIES(ENTRIES), .SW(SW)) u_lk_match (
    .addr (lk_addr),
    .tags (tag_q),
    .big  (big_q),
    .hit  (lk_hit),
    .slot (lk_slot)
  );

  slb_seg_match #(.ENTRIES(ENTRIES), .SW(SW)) u_cmd_match (
    .addr (c_addr),
    .tags (tag_q),
    .big  (big_q),
    .hit  (c_hit),
    .slot (c_slot)
  );

  slb_store_check #(.ENTRIES(ENTRIES), .PS_COUNT(PS_COUNT), .PS_ENC(PS_ENC)) u_check (
    .opnd      (cmd_addr),
    .vsid      (cmd_vsid),
    .one_tb_en (one_tb_en),
    .ok        (chk_ok),
    .pidx      (chk_pidx)
  );

  always_comb begin
    lk_shift = '0;
    if (lk_hit) lk_shift = PS_SHIFT[pidx_q[lk_slot]*SHIFT_W +: SHIFT_W];
  end

  assign wr_en  = (op == OP_STORE) && chk_ok;
  assign rd_idx = (op == OP_FIND) ? c_slot : slot_i;

  always_ff @(posedge clk) begin
    if (wr_en) vsid_mem[slot_i] <= cmd_vsid;
    vsid_q <= vsid_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q        <= '0;
      big_q        <= '0;
      pidx_q       <= '0;
      tag_rd_q     <= '0;
      kind_q       <= RK_TAG;
      rd_valid     <= 1'b0;
      err          <= 1'b0;
      flush_local  <= 1'b0;
      flush_global <= 1'b0;
    end else begin
      rd_valid     <= 1'b0;
      err          <= 1'b0;
      flush_local  <= 1'b0;
      flush_global <= 1'b0;
      unique case (op)
        OP_STORE: begin
          if (chk_ok) begin
            tag_q[slot_i]  <= cmd_addr[ADDR_W-1:TAG_LO];
            big_q[slot_i]  <= cmd_vsid[ADDR_W-2];
            pidx_q[slot_i] <= chk_pidx;
          end else begin
            err <= 1'b1;
          end
        end
        OP_RTAG: begin
          if (slot_in_range) begin
            rd_valid <= 1'b1;
            kind_q   <= RK_TAG;
            tag_rd_q <= {tag_q[slot_i], {TAG_LO{1'b0}}};
          end else begin
            err <= 1'b1;
          end
        end
        OP_RVSID: begin
          if (slot_in_range) begin
            rd_valid <= 1'b1;
            kind_q   <= RK_VSID;
          end else begin
            err <= 1'b1;
          end
        end
        OP_FIND: begin
          rd_valid <= 1'b1;
          kind_q   <= c_hit ? RK_VSID : RK_ONES;
        end
        OP_INVALL: begin
          for (int i = 1; i < ENTRIES; i++) tag_q[i][0] <= 1'b0;
          flush_local <= |valid_v[ENTRIES-1:1];
        end
        OP_INVL, OP_INVG: begin
          if (c_hit) begin
            tag_q[c_slot][0] <= 1'b0;
            flush_local      <= (op == OP_INVL);
            flush_global     <= (op == OP_INVG);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (kind_q)
      RK_VSID: rd_data = vsid_q;
      RK_ONES: rd_data = '1;
      default: rd_data = tag_rd_q;
    endcase
  end
endmodule

// File: rtl/slb_checker.sv
module slb_checker
  import slb_pkg::*;
#(
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          mode64,
  input logic [2:0]    cmd_op,
  input logic [63:0]   cmd_addr,
  input logic [63:0]   lk_addr,
  input logic          lk_hit,
  input logic [SW-1:0] lk_slot,
  input logic          rd_valid,
  input logic [63:0]   rd_data,
  input logic          err,
  input logic          flush_local,
  input logic          flush_global
);
  // R4: a rejected store leaves the lookup result untouched
  a_r4_reject_no_change: assert property (@(posedge clk) disable iff (rst)
    (err && $past(cmd_op) == OP_STORE && $stable(lk_addr))
      |-> (lk_hit == $past(lk_hit) && lk_slot == $past(lk_slot)));

  // R6: an error never comes with a read result
  a_r6_err_no_data: assert property (@(posedge clk) disable iff (rst)
    err |-> !rd_valid);

  // R7: a find that misses returns all ones
  a_r7_find_miss_ones: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_FIND && mode64 && cmd_addr == lk_addr && !lk_hit)
      |=> (rd_valid && rd_data == '1));

  // R8: slot 0 survives invalidate-all
  a_r8_slot0_kept: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_INVALL && lk_hit && lk_slot == '0)
      |=> (!$stable(lk_addr) || (lk_hit && lk_slot == '0)));

  // R9: a local invalidate that hits requests a local flush only
  a_r9_local_flush: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_INVL && cmd_addr == lk_addr && lk_hit)
      |=> (flush_local && !flush_global));

  // R9: flush requests never coincide with read results or errors
  a_r9_flush_alone: assert property (@(posedge clk) disable iff (rst)
    (flush_local || flush_global) |-> (!rd_valid && !err));
endmodule

bind seg_lookaside slb_checker #(.SW($clog2(ENTRIES))) u_slb_checker (
  .clk          (clk),
  .rst          (rst),
  .mode64       (mode64),
  .cmd_op       (cmd_op),
  .cmd_addr     (cmd_addr),
  .lk_addr      (lk_addr),
  .lk_hit       (lk_hit),
  .lk_slot      (lk_slot),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .err          (err),
  .flush_local  (flush_local),
  .flush_global (flush_global)
);

// File: tb/seg_lookaside_test.sv
`timescale 1ns/1ps
module seg_lookaside_test;
  localparam int N = 32;
  localparam logic [63:0] VBIT = 64'h0000_0000_0800_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode64 = 1'b1;
  logic        one_tb_en = 1'b1;
  logic [2:0]  cmd_op = 3'd0;
  logic [63:0] cmd_addr = '0;
  logic [63:0] cmd_vsid = '0;
  logic [63:0] lk_addr = '0;
  logic        lk_hit;
  logic [4:0]  lk_slot;
  logic [5:0]  lk_shift;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        err;
  logic        flush_local;
  logic        flush_global;

  seg_lookaside uut (
    .clk(clk), .rst(rst), .mode64(mode64), .one_tb_en(one_tb_en),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_vsid(cmd_vsid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_shift(lk_shift),
    .rd_valid(rd_valid), .rd_data(rd_data), .err(err),
    .flush_local(flush_local), .flush_global(flush_global)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference table
  logic [63:0] m_tag [N];
  logic [63:0] m_vsid[N];
  bit          m_big [N];
  bit          m_wr  [N];
  int          m_sh  [N];

  function automatic int shift_of(logic [2:0] code);
    case (code)
      3'd0: return 12;
      3'd4: return 16;
      3'd5: return 24;
      default: return 0;
    endcase
  endfunction

  function automatic int mlook(logic [63:0] a);
    for (int i = 0; i < N; i++) begin
      logic [63:0] key;
      key = m_big[i] ? ((a & ~64'hFF_FFFF_FFFF) | VBIT) : ((a & ~64'hFFF_FFFF) | VBIT);
      if (m_tag[i] == key) return i;
    end
    return -1;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(logic [2:0] op, logic [63:0] a, logic [63:0] v, logic [63:0] l);
    int s;
    int slot;
    bit e_rv, e_err, e_fl, e_fg;
    logic [63:0] e_rd;
    string tag;
    cmd_op = op; cmd_addr = a; cmd_vsid = v; lk_addr = l;
    #1;
    // R1, R2, R5: lookup reflects the table before this cycle's command
    s = mlook(l);
    chk("R1,R2", "lk_hit", 64'(lk_hit), 64'(s >= 0));
    if (s >= 0) begin
      chk("R2", "lk_slot", 64'(lk_slot), 64'(s));
      chk("R5", "lk_shift", 64'(lk_shift), 64'(m_sh[s]));
    end
    e_rv = 0; e_err = 0; e_fl = 0; e_fg = 0; e_rd = '0;
    slot = int'(a[11:0]);
    tag = "R11";
    case (op)
      3'd1: begin
        bit bad;
        bad = (slot >= N) || (a[26:12] != 0) || (v[63] == 1'b1) ||
              (v[62] && !one_tb_en) || (shift_of(v[6:4]) == 0);
        if (bad) begin
          e_err = 1; tag = "R4";
        end else begin
          tag = "R3";
          m_tag[slot] = {a[63:12], 12'h000};
          m_vsid[slot] = v; m_big[slot] = v[62]; m_wr[slot] = 1;
          m_sh[slot] = shift_of(v[6:4]);
        end
      end
      3'd2, 3'd3: begin
        tag = "R6";
        if (slot >= N) e_err = 1;
        else begin
          e_rv = 1;
          e_rd = (op == 3'd2) ? m_tag[slot] : m_vsid[slot];
        end
      end
      3'd4: begin
        int f;
        tag = "R7";
        f = mlook(mode64 ? a : {32'h0, a[31:0]});
        e_rv = 1;
        e_rd = (f >= 0) ? m_vsid[f] : '1;
      end
      3'd5: begin
        tag = "R8";
        for (int i = 1; i < N; i++) begin
          if (m_tag[i][27]) e_fl = 1;
          m_tag[i][27] = 1'b0;
        end
      end
      3'd6, 3'd7: begin
        int f;
        tag = "R9";
        f = mlook(a);
        if (f >= 0) begin
          m_tag[f][27] = 1'b0;
          if (op == 3'd6) e_fl = 1; else e_fg = 1;
        end
      end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rd_valid", 64'(rd_valid), 64'(e_rv));
    chk(tag, "err", 64'(err), 64'(e_err));
    chk(tag, "flush_local", 64'(flush_local), 64'(e_fl));
    chk(tag, "flush_global", 64'(flush_global), 64'(e_fg));
    if (e_rv) chk(tag, "rd_data", rd_data, e_rd);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  logic [63:0] bases[4];

  initial begin
    logic [63:0] A, B, C, D;
    for (int i = 0; i < N; i++) begin
      m_tag[i] = '0; m_vsid[i] = '0; m_big[i] = 0; m_wr[i] = 0; m_sh[i] = 0;
    end
    A = 64'h1234_5678_9000_0000;
    B = 64'hABCD_EF00_0000_0000;
    C = 64'h0000_0000_3000_0000;
    D = 64'h7777_0000_5000_0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "lk_hit", 64'(lk_hit), 64'd0);
    chk("R10", "rd_valid", 64'(rd_valid), 64'd0);
    chk("R10", "rd_data", rd_data, 64'd0);
    chk("R10", "err", 64'(err), 64'd0);
    chk("R10", "flush", 64'({flush_local, flush_global}), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    run(3'd0, 0, 0, A);                                          // R11 idle
    run(3'd1, A | VBIT | 64'd0, 64'h0000_0ABC_DEF0_0000, A);     // R3 slot 0, miss this cycle
    run(3'd0, 0, 0, A | 64'h123_4567);                           // R3 visible
    run(3'd1, B | VBIT | 64'd3, 64'h4000_0001_2345_0040, B);     // R1 1 TB, code 4
    run(3'd1, B | VBIT | 64'd5, 64'h4000_0009_8765_0050, B | 64'h12_3456_7890); // R2 duplicate
    run(3'd0, 0, 0, B | 64'h12_3456_7890);                       // R2 lowest wins
    run(3'd1, A | VBIT | 64'd40, 64'h0, A);                      // R4 slot range
    run(3'd1, A | VBIT | 64'h8006, 64'h0, A);                    // R4 reserved bit
    run(3'd1, A | VBIT | 64'd6, 64'h8000_0000_0000_0000, A);     // R4 size code 10
    one_tb_en = 1'b0;
    run(3'd1, B | VBIT | 64'd6, 64'h4000_0000_0000_0000, B);     // R4 1 TB disabled
    one_tb_en = 1'b1;
    run(3'd1, A | VBIT | 64'd6, 64'h0000_0000_0000_0020, A);     // R4 bad page code
    run(3'd2, 64'd3, 0, B);                                      // R6 tag read
    run(3'd3, 64'd5, 0, B);                                      // R6 vsid read
    run(3'd2, 64'd33, 0, B);                                     // R6 out of range
    run(3'd3, 64'hFFF, 0, B);                                    // R6 out of range
    run(3'd1, C | VBIT | 64'd7, 64'h0000_0000_0000_0050, C);     // slot 7
    mode64 = 1'b0;
    run(3'd4, 64'hFFFF_0000_3123_4567, 0, C);                    // R7 masked hit
    mode64 = 1'b1;
    run(3'd4, 64'hFFFF_0000_3123_4567, 0, 64'hFFFF_0000_3123_4567); // R7 miss
    run(3'd1, D | VBIT | 64'd9, 64'h0000_1111_2222_0000, D);     // same-cycle store
    run(3'd4, D | 64'h42, 0, D);                                 // R7 hit
    run(3'd6, B | 64'h5, 0, B);                                  // R9 local, same cycle
    run(3'd7, B, 0, B);                                          // R9 global
    run(3'd7, B, 0, B);                                          // R9 miss
    run(3'd5, 0, 0, A);                                          // R8 flush
    run(3'd5, 0, 0, A);                                          // R8 nothing left
    run(3'd2, 64'd0, 0, C);                                      // R8 slot 0 still valid

    bases[0] = A; bases[1] = B; bases[2] = C; bases[3] = D;
    for (int n = 0; n < 1500; n++) begin
      logic [2:0]  op;
      logic [63:0] a, v, l, base;
      int sl;
      op = 3'($urandom_range(0, 7));
      base = bases[$urandom_range(0, 3)];
      if ($urandom_range(0, 2) == 0) base = base & ~64'hFF_FFFF_FFFF;
      sl = $urandom_range(0, 35);
      a = (base & ~64'hFFF_FFFF) | 64'(sl);
      if ($urandom_range(0, 7) != 0) a = a | VBIT;
      if ($urandom_range(0, 15) == 0) a = a | 64'h1000;
      v = {$urandom, $urandom};
      v[63:62] = ($urandom_range(0, 9) == 0) ? 2'b10 : 2'($urandom_range(0, 1));
      case ($urandom_range(0, 3))
        0: v[6:4] = 3'd0;
        1: v[6:4] = 3'd4;
        2: v[6:4] = 3'd5;
        default: v[6:4] = 3'd2;
      endcase
      if (op == 3'd3 && sl < N && !m_wr[sl]) op = 3'd2;
      if (op != 3'd1 && op != 3'd2 && op != 3'd3) a = base | 64'($urandom_range(0, 65535));
      if (op == 3'd4 && $urandom_range(0, 1) == 0) a = a | 64'hFFFF_0000_0000_0000;
      l = bases[$urandom_range(0, 3)] | 64'($urandom);
      if ($urandom_range(0, 31) == 0) mode64 = ~mode64;
      if ($urandom_range(0, 31) == 0) one_tb_en = ~one_tb_en;
      run(op, a, v, l);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule